// File: doc/BRIEF.md
# Load/Store Alignment Gate with Reservation Tracking

This block sits in front of address translation in a load/store pipeline. Every memory request carries an address, an access size (1, 2, 4 or 8 bytes), a read/write flag and an atomic flag. An atomic read is a load-reserved access. An atomic write is a store-conditional access. The gate checks that the address is a multiple of the access size. A misaligned request raises a load or store trap and never reaches translation. An aligned request is passed on as a go-ahead carrying its address and direction.

The gate also holds one reservation. An aligned load-reserved access records its full address and otherwise proceeds as a normal load. A store-conditional is sent to translation only when a reservation is held and its address equals the recorded one exactly. Its pass/fail result is reported with a 0 for success and a 1 for failure. A separate yield input drops the reservation at any time.

The reservation machine has two states. RSV_EMPTY holds the all-ones invalid address. RSV_HELD holds a recorded address. The transitions are:
- LR_CAPTURE: RSV_EMPTY to RSV_HELD on an aligned load-reserved access with no yield.
- LR_REPLACE: RSV_HELD to RSV_HELD on an aligned load-reserved access; the stored address is replaced.
- DROP: RSV_HELD to RSV_EMPTY on a yield or on any aligned store-conditional.

The response stage is a registered state that is decoded into the outputs, one cycle after the request. Its states are RSP_NONE, RSP_TRAP_LD, RSP_TRAP_ST, RSP_GO, RSP_SC_PASS and RSP_SC_FAIL.

Top module: `mem_access_gate`

## Requirements
- R1: The size code req_size selects 1, 2, 4 or 8 bytes (codes 0, 1, 2, 3). A valid read whose address is not a multiple of its size raises trap_load_misal one cycle later. In that cycle xlate_go, trap_store_misal and sc_done are low.
- R2: A valid misaligned write, atomic or not, raises trap_store_misal one cycle later. In that cycle xlate_go, trap_load_misal and sc_done are low.
- R3: A valid aligned non-atomic request raises xlate_go one cycle later. In that cycle xlate_addr equals the request address and xlate_write equals the request write flag.
- R4: A valid aligned load-reserved request records its address as the reservation. One cycle later it raises xlate_go with xlate_write low, like a plain load.
- R5: A valid aligned store-conditional passes only when a reservation is held and its address equals the recorded address in every bit. One cycle later a pass shows sc_done=1, sc_fail=0, xlate_go=1, xlate_write=1 and xlate_addr equal to the request address.
- R6: A failing store-conditional shows sc_done=1 and sc_fail=1 one cycle later, with xlate_go low, so no write goes out.
- R7: resv_yield drops the reservation. It takes priority over a load-reserved request in the same cycle. A store-conditional in the same cycle is judged against the reservation held before that edge.
- R8: After reset no reservation is held. The stored address is all ones, and a store-conditional to any address, including all ones, fails. All outputs are low until the first request.
- R9: Every aligned store-conditional drops the reservation, whether it passes or fails.
- R10: A misaligned request leaves the reservation unchanged and produces no store-conditional result.
- R11: A cycle with req_valid low produces all trap, go and result outputs low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_write | input | 1 | 1 = store, 0 = load |
| req_atomic | input | 1 | Load-reserved (read) or store-conditional (write) |
| resv_yield | input | 1 | Drop the reservation |
| trap_load_misal | output | 1 | Misaligned load trap |
| trap_store_misal | output | 1 | Misaligned store trap |
| xlate_go | output | 1 | Request forwarded to translation |
| xlate_addr | output | ADDR_W | Forwarded address |
| xlate_write | output | 1 | Forwarded direction |
| sc_done | output | 1 | Store-conditional result valid |
| sc_fail | output | 1 | Store-conditional result: 0 pass, 1 fail |

## Verification
On every cycle the assertions check the following:
- The two traps are never raised together.
- A failed conditional store never raises xlate_go.
- An idle cycle yields idle outputs.
- The empty reservation always holds the all-ones value.
- A yield or a store-conditional always empties the reservation.
- An aligned load-reserved access always captures its address.

Whether a store-conditional passes depends on the history of earlier requests. That history is shown only by the bench's scenarios, which compare against a reference model:
- a reserve followed by a matching conditional store, then a repeated store;
- near-miss addresses;
- a yield in the same cycle as a reserve;
- misaligned reserves that must not disturb the held address;
- long random mixes over a small pool of addresses.

// File: rtl/mag_pkg.sv
package mag_pkg;

    typedef enum logic [1:0] {
        RSV_EMPTY = 2'd0,
        RSV_HELD  = 2'd1
    } rsv_state_t;

    typedef enum logic [2:0] {
        RSP_NONE    = 3'd0,
        RSP_TRAP_LD = 3'd1,
        RSP_TRAP_ST = 3'd2,
        RSP_GO      = 3'd3,
        RSP_SC_PASS = 3'd4,
        RSP_SC_FAIL = 3'd5
    } rsp_state_t;

    localparam int SIZE_CODES = 4;

endpackage

// File: rtl/mag_align_chk.sv
module mag_align_chk #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size_code,
    output logic              misaligned
);
    localparam int LSB_W = 3;

    logic [LSB_W-1:0] low_mask;

    always_comb begin
        unique case (size_code)
            2'd0: low_mask = 3'b000;
            2'd1: low_mask = 3'b001;
            2'd2: low_mask = 3'b011;
            2'd3: low_mask = 3'b111;
            default: low_mask = 3'b111;
        endcase
    end

    assign misaligned = |(addr[LSB_W-1:0] & low_mask);

endmodule

// File: rtl/mag_resv_fsm.sv
module mag_resv_fsm
    import mag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_ok,
    input  logic              sc_ok,
    input  logic              yield_i,
    input  logic [ADDR_W-1:0] addr,
    output logic              sc_match
);
    localparam logic [ADDR_W-1:0] INVALID_ADDR = '1;

    rsv_state_t        state_q, state_d;
    logic [ADDR_W-1:0] resv_q, resv_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            resv_q  <= INVALID_ADDR;
        end else begin
            state_q <= state_d;
            resv_q  <= resv_d;
        end
    end

    always_comb begin
        state_d = state_q;
        resv_d  = resv_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (lr_ok && !yield_i) begin
                    state_d = RSV_HELD;
                    resv_d  = addr;
                end
            end
            RSV_HELD: begin
                if (yield_i || sc_ok) begin
                    state_d = RSV_EMPTY;
                    resv_d  = INVALID_ADDR;
                end else if (lr_ok) begin
                    resv_d  = addr;
                end
            end
            default: begin
                state_d = RSV_EMPTY;
                resv_d  = INVALID_ADDR;
            end
        endcase
    end

    assign sc_match = (state_q == RSV_HELD) && (addr == resv_q);

    // R8
    empty_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RSV_EMPTY) |-> (resv_q == INVALID_ADDR));

    // R7
    yield_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yield_i |=> (state_q == RSV_EMPTY));

    // R9
    sc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |=> (state_q == RSV_EMPTY));

    // R4
    lr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_ok && !yield_i) |=> (state_q == RSV_HELD && resv_q == $past(addr)));

endmodule

// File: rtl/mag_resp_stage.sv
module mag_resp_stage
    import mag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_atomic,
    input  logic              misaligned,
    input  logic              sc_match,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              trap_ld,
    output logic              trap_st,
    output logic              go,
    output logic [ADDR_W-1:0] go_addr,
    output logic              go_write,
    output logic              sc_done,
    output logic              sc_fail
);
    rsp_state_t        rsp_q, rsp_d;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;

    always_comb begin
        rsp_d = RSP_NONE;
        if (req_valid) begin
            if (misaligned)
                rsp_d = req_write ? RSP_TRAP_ST : RSP_TRAP_LD;
            else if (req_write && req_atomic)
                rsp_d = sc_match ? RSP_SC_PASS : RSP_SC_FAIL;
            else
                rsp_d = RSP_GO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q  <= RSP_NONE;
            addr_q <= '0;
            wr_q   <= 1'b0;
        end else begin
            rsp_q  <= rsp_d;
            addr_q <= req_addr;
            wr_q   <= req_write;
        end
    end

    always_comb begin
        trap_ld = 1'b0;
        trap_st = 1'b0;
        go      = 1'b0;
        sc_done = 1'b0;
        sc_fail = 1'b0;
        unique case (rsp_q)
            RSP_NONE:    ;
            RSP_TRAP_LD: trap_ld = 1'b1;
            RSP_TRAP_ST: trap_st = 1'b1;
            RSP_GO:      go      = 1'b1;
            RSP_SC_PASS: begin
                go      = 1'b1;
                sc_done = 1'b1;
            end
            RSP_SC_FAIL: begin
                sc_done = 1'b1;
                sc_fail = 1'b1;
            end
            default: ;
        endcase
    end

    assign go_addr  = go ? addr_q : '0;
    assign go_write = go & wr_q;

    // R1
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_ld && trap_st));

    // R6
    sc_fail_nogo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && sc_fail) |-> !go);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(go || trap_ld || trap_st || sc_done));

endmodule

// File: rtl/mem_access_gate.sv
module mem_access_gate
    import mag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_atomic,
    input  logic              resv_yield,
    output logic              trap_load_misal,
    output logic              trap_store_misal,
    output logic              xlate_go,
    output logic [ADDR_W-1:0] xlate_addr,
    output logic              xlate_write,
    output logic              sc_done,
    output logic              sc_fail
);
    logic misal;
    logic sc_match;
    logic lr_ok;
    logic sc_ok;

    mag_align_chk #(.ADDR_W(ADDR_W)) align_i (
        .addr       (req_addr),
        .size_code  (req_size),
        .misaligned (misal)
    );

    assign lr_ok = req_valid && !misal && req_atomic && !req_write;
    assign sc_ok = req_valid && !misal && req_atomic && req_write;

    mag_resv_fsm #(.ADDR_W(ADDR_W)) resv_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lr_ok    (lr_ok),
        .sc_ok    (sc_ok),
        .yield_i  (resv_yield),
        .addr     (req_addr),
        .sc_match (sc_match)
    );

    mag_resp_stage #(.ADDR_W(ADDR_W)) resp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_atomic (req_atomic),
        .misaligned (misal),
        .sc_match   (sc_match),
        .req_addr   (req_addr),
        .trap_ld    (trap_load_misal),
        .trap_st    (trap_store_misal),
        .go         (xlate_go),
        .go_addr    (xlate_addr),
        .go_write   (xlate_write),
        .sc_done    (sc_done),
        .sc_fail    (sc_fail)
    );

    // R2
    trap_st_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_store_misal |-> ($past(req_valid) && $past(req_write)));

endmodule

// File: tb/mem_access_gate_tb.sv
module mem_access_gate_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic          req_atomic = 1'b0;
    logic          resv_yield = 1'b0;
    logic          trap_load_misal, trap_store_misal, xlate_go, xlate_write;
    logic          sc_done, sc_fail;
    logic [AW-1:0] xlate_addr;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    bit            m_held = 1'b0;
    logic [AW-1:0] m_addr = '1;
    // expected outputs of the pending step
    bit e_tl, e_ts, e_go, e_wr, e_scd, e_scf;
    logic [AW-1:0] e_addr;

    always #5 clk = ~clk;

    mem_access_gate #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_atomic(req_atomic),
        .resv_yield(resv_yield), .trap_load_misal(trap_load_misal),
        .trap_store_misal(trap_store_misal), .xlate_go(xlate_go),
        .xlate_addr(xlate_addr), .xlate_write(xlate_write),
        .sc_done(sc_done), .sc_fail(sc_fail)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_misal(input logic [AW-1:0] a, input logic [1:0] sz);
        int bytes = 1 << sz;
        return (a % bytes) != 0;
    endfunction

    // compute expectations from model, then advance model
    task automatic predict(input bit v, input logic [AW-1:0] a, input logic [1:0] sz,
                           input bit w, input bit at, input bit y);
        bit pass;
        e_tl = 0; e_ts = 0; e_go = 0; e_wr = 0; e_scd = 0; e_scf = 0; e_addr = '0;
        if (v) begin
            if (is_misal(a, sz)) begin
                if (w) e_ts = 1; else e_tl = 1;
            end else if (w && at) begin
                pass  = m_held && (a == m_addr);
                e_scd = 1; e_scf = !pass;
                e_go  = pass; e_wr = pass; e_addr = pass ? a : '0;
                m_held = 0;
            end else begin
                e_go = 1; e_wr = w; e_addr = a;
                if (at) begin m_held = 1; m_addr = a; end
            end
        end
        if (y) m_held = 0;
    endtask

    task automatic compare_outs(input string tag);
        chk({tag, " trap_load"},  trap_load_misal,  e_tl);
        chk({tag, " trap_store"}, trap_store_misal, e_ts);
        chk({tag, " go"},         xlate_go,         e_go);
        chk({tag, " write"},      xlate_write,      e_wr);
        chk({tag, " addr"},       xlate_addr,       e_addr);
        chk({tag, " sc_done"},    sc_done,          e_scd);
        chk({tag, " sc_fail"},    sc_fail,          e_scf);
    endtask

    // drive one request at negedge, check its response one cycle later
    task automatic step(input string tag, input bit v, input logic [AW-1:0] a,
                        input logic [1:0] sz, input bit w, input bit at, input bit y);
        req_valid = v; req_addr = a; req_size = sz;
        req_write = w; req_atomic = at; resv_yield = y;
        predict(v, a, sz, w, at, y);
        @(negedge clk);
        compare_outs(tag);
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] pool [8];
        pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1008; pool[2] = 32'h0000_1001;
        pool[3] = 32'h0000_1004; pool[4] = 32'hFFFF_FFFF; pool[5] = 32'h8000_1000;
        pool[6] = 32'h0000_1002; pool[7] = 32'h0000_1006;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        predict(0, '0, 0, 0, 0, 0);
        compare_outs("R8 reset");

        step("R8 sc all-ones after reset", 1, 32'hFFFF_FFFF, 2'd0, 1, 1, 0);
        step("R11 idle",                   0, 32'h0,         2'd0, 0, 0, 0);
        for (int s = 1; s < 4; s++) begin
            step("R1 misaligned load",  1, 32'h0000_2001, 2'(s), 0, 0, 0);
            step("R2 misaligned store", 1, 32'h0000_2001, 2'(s), 1, 0, 0);
        end
        step("R2 misaligned sc",     1, 32'h0000_2004, 2'd3, 1, 1, 0);
        step("R3 aligned store",     1, 32'h0000_2008, 2'd3, 1, 0, 0);
        step("R3 aligned byte load", 1, 32'h0000_2007, 2'd0, 0, 0, 0);
        step("R4 lr",                1, 32'h0000_3000, 2'd2, 0, 1, 0);
        step("R5 sc pass",           1, 32'h0000_3000, 2'd2, 1, 1, 0);
        step("R9 sc repeat fails",   1, 32'h0000_3000, 2'd2, 1, 1, 0);
        step("R4 lr",                1, 32'h0000_3000, 2'd2, 0, 1, 0);
        step("R6 sc near miss",      1, 32'h0000_3004, 2'd2, 1, 1, 0);
        step("R9 sc after fail",     1, 32'h0000_3000, 2'd2, 1, 1, 0);
        step("R4 lr",                1, 32'h0000_3000, 2'd3, 0, 1, 0);
        step("R7 yield",             0, 32'h0,         2'd0, 0, 0, 1);
        step("R7 sc after yield",    1, 32'h0000_3000, 2'd3, 1, 1, 0);
        step("R7 lr with yield",     1, 32'h0000_3000, 2'd3, 0, 1, 1);
        step("R7 sc after lr+yield", 1, 32'h0000_3000, 2'd3, 1, 1, 0);
        step("R4 lr",                1, 32'h0000_4000, 2'd3, 0, 1, 0);
        step("R7 sc with yield",     1, 32'h0000_4000, 2'd3, 1, 1, 1);
        step("R4 lr",                1, 32'h0000_5000, 2'd3, 0, 1, 0);
        step("R10 misaligned lr",    1, 32'h0000_6002, 2'd3, 0, 1, 0);
        step("R10 misaligned sc",    1, 32'h0000_5001, 2'd1, 1, 1, 0);
        step("R10 sc still held",    1, 32'h0000_5000, 2'd3, 1, 1, 0);

        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            step("R5/R6/R9 random", r < 90, pool[$urandom_range(0, 7)],
                 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 99) < 60, $urandom_range(0, 99) < 8);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule